// File: doc/BRIEF.md
# Alternate-Space Move Unit

This unit carries out a privileged transfer between one CPU register and memory. The memory access does not take its address space from the current privilege level. It takes it from one of two small function-code registers. The destination code tags stores (register to memory) and the source code tags loads (memory to register). Bit 2 of the selected code picks supervisor space or user space. This lets supervisor software reach user memory, or the reverse, one operand at a time.

A decode stage pulses `start` with the opcode, its extension word and the current privilege mode. The unit checks the instruction and rejects a bad one with a one-cycle fault pulse and a cause code. A good instruction runs as follows:

1. The unit works out a register-indirect address from an address register.
2. It performs one handshaked bus access tagged with the latched function code.
3. It writes the loaded operand back, then writes back the updated address register if the mode needs it.
4. It pulses `done`.

The register file is external and has two combinational read ports and one write port. Control software sets the function-code registers through a narrow write/read port.

Top module: `altspace_mover`

## Requirements
- R1: An instruction is accepted only when `opcode[15:8]` is 0x0E. The operand size is `opcode[7:6]`: 00 is byte, 01 is word and 10 is long. A mismatching opcode or size 11 gives `fault` with `fault_code` 2 (illegal), and no bus access is made.
- R2: When `supervisor` is 0 at `start`, the unit pulses `fault` with `fault_code` 1 (privilege) one cycle later and never raises `mem_req`. This check takes priority over every other fault.
- R3: The register moved is selected by `ext[14:12]`. It is an address register when `ext[15]` is 1 and a data register when `ext[15]` is 0. The register-file index is `{ext[15], ext[14:12]}`, so address registers are entries 8 to 15.
- R4: When `ext[11]` is 1, the register is stored to memory (`mem_we`=1, `mem_wdata` = register value) with the destination code on `mem_fc`. When `ext[11]` is 0, memory is loaded with the source code on `mem_fc`.
- R5: A load into an address register writes the operand sign-extended from the operand size to 32 bits.
- R6: A load into a data register replaces only the low 8 or 16 bits (or all 32 for long) and keeps the other bits.
- R7: Writing a function-code register (`cr_sel` 0 = source, 1 = destination) stores `cr_wdata[2:0]` only. `cr_rdata` returns the stored 3-bit value of the selected register. Both reset to 0.
- R8: During every access, `mem_super` equals bit 2 of `mem_fc`: 1 means supervisor space and 0 means user space.
- R9: In mode 3 (`opcode[5:3]`), the access uses address register An, selected by `opcode[2:0]`. An is then written with An + step. The step is 1, 2 or 4 bytes by size, except that register 7 with byte size steps by 2.
- R10: In mode 4, the access uses An − step, and An is written with that same address. Mode 2 uses An and leaves it unchanged.
- R11: Modes 0, 1, 5, 6 and 7 give `fault` with `fault_code` 3 (address) and no bus access.
- R12: `done` is a one-cycle pulse. It follows the acknowledge by 1 + (1 if load) + (1 if mode 3 or 4) cycles. The function code is latched at `start`, so a function-code write during an instruction affects only later instructions.
- R13: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_fc` and `mem_we` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Instruction valid pulse |
| opcode | input | 16 | Instruction word |
| ext | input | 16 | Extension word |
| supervisor | input | 1 | Current privilege mode, 1 = supervisor |
| cr_we | input | 1 | Function-code register write strobe |
| cr_sel | input | 1 | 0 = source code, 1 = destination code |
| cr_wdata | input | 32 | Function-code write value |
| cr_rdata | output | 3 | Selected function-code register |
| rf_base_addr | output | 4 | Register-file read index for the address register |
| rf_base_data | input | 32 | Value of `rf_base_addr` |
| rf_xfer_addr | output | 4 | Register-file read index for the moved register |
| rf_xfer_data | input | 32 | Value of `rf_xfer_addr` |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write value |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_size | output | 2 | Access size, same encoding as the opcode |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data, right-aligned |
| mem_fc | output | 3 | Function code of the access |
| mem_super | output | 1 | 1 = supervisor space |
| mem_ack | input | 1 | Bus acknowledge |
| mem_rdata | input | 32 | Load data, right-aligned |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Exception pulse |
| fault_code | output | 2 | 1 = privilege, 2 = illegal, 3 = address |

## Verification
The main function is tried with loads in both register classes, using byte, word and long sizes. Each load uses data whose sign bit is set in one case and clear in another, so sign extension is told apart from partial merging. Postincrement and predecrement are run on an ordinary register and on register 7, which separates the stack-alignment step from the plain size step. Function codes with bit 2 set and clear are mixed, and a code is rewritten while an acknowledge is held off, to tell a code latched at start from a live one. Each fault cause is provoked alone, and a combined case checks that privilege wins.

// File: rtl/altspace_pkg.sv
`timescale 1ns/1ps
package altspace_pkg;
  localparam int WORD_W = 32;
  localparam int FC_W   = 3;
  localparam int RIDX_W = 4;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_PRIV    = 2'd1,
    FLT_ILLEGAL = 2'd2,
    FLT_ADDR    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACC, ST_WBD, ST_WBA, ST_FIN
  } state_e;

  // Address step for postincrement / predecrement; stack pointer stays even.
  function automatic logic [WORD_W-1:0] step_bytes(input logic [1:0] sz,
                                                   input logic [2:0] areg);
    case (sz)
      SZ_BYTE: return (areg == 3'd7) ? WORD_W'(2) : WORD_W'(1);
      SZ_WORD: return WORD_W'(2);
      default: return WORD_W'(4);
    endcase
  endfunction

  // Combine a loaded operand with the old register value.
  function automatic logic [WORD_W-1:0] merge_load(input logic [1:0] sz,
                                                   input logic to_addr,
                                                   input logic [WORD_W-1:0] old_v,
                                                   input logic [WORD_W-1:0] mem_v);
    case (sz)
      SZ_BYTE: return to_addr ? {{(WORD_W-8){mem_v[7]}}, mem_v[7:0]}
                              : {old_v[WORD_W-1:8], mem_v[7:0]};
      SZ_WORD: return to_addr ? {{(WORD_W-16){mem_v[15]}}, mem_v[15:0]}
                              : {old_v[WORD_W-1:16], mem_v[15:0]};
      default: return mem_v;
    endcase
  endfunction
endpackage

// File: rtl/altspace_fcregs.sv
`timescale 1ns/1ps
module altspace_fcregs
  import altspace_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            sel,
  input  logic [FC_W-1:0] wdata,
  output logic [FC_W-1:0] rdata,
  output logic [FC_W-1:0] src_fc,
  output logic [FC_W-1:0] dst_fc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_fc <= '0;
      dst_fc <= '0;
    end else if (we) begin
      if (sel) dst_fc <= wdata;
      else     src_fc <= wdata;
    end
  end

  assign rdata = sel ? dst_fc : src_fc;
endmodule

// File: rtl/altspace_decode.sv
`timescale 1ns/1ps
module altspace_decode
  import altspace_pkg::*;
(
  input  logic              [15:0] opcode,
  input  logic              [4:0]  ext_hi,      // ext[15:11]
  input  logic                     supervisor,
  output fault_e                   fault_o,
  output logic              [1:0]  size_o,
  output logic              [2:0]  mode_o,
  output logic              [2:0]  areg_o,
  output logic [RIDX_W-1:0]        xidx_o,
  output logic                     store_o
);
  logic match;
  logic mode_ok;

  assign size_o  = opcode[7:6];
  assign mode_o  = opcode[5:3];
  assign areg_o  = opcode[2:0];
  assign xidx_o  = {ext_hi[4], ext_hi[3:1]};
  assign store_o = ext_hi[0];
  assign match   = (opcode[15:8] == 8'h0E) && (opcode[7:6] != 2'b11);
  assign mode_ok = (mode_o == 3'd2) || (mode_o == 3'd3) || (mode_o == 3'd4);

  always_comb begin
    if (!supervisor)   fault_o = FLT_PRIV;
    else if (!match)   fault_o = FLT_ILLEGAL;
    else if (!mode_ok) fault_o = FLT_ADDR;
    else               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/altspace_agen.sv
`timescale 1ns/1ps
module altspace_agen
  import altspace_pkg::*;
(
  input  logic [WORD_W-1:0] base,
  input  logic [1:0]        size,
  input  logic [2:0]        mode,
  input  logic [2:0]        areg,
  output logic [WORD_W-1:0] acc_addr,
  output logic [WORD_W-1:0] new_areg,
  output logic              upd
);
  logic [WORD_W-1:0] step;
  logic [WORD_W-1:0] pre;

  assign step     = step_bytes(size, areg);
  assign pre      = base - step;
  assign acc_addr = (mode == 3'd4) ? pre : base;
  assign new_areg = (mode == 3'd3) ? base + step : pre;
  assign upd      = (mode == 3'd3) || (mode == 3'd4);
endmodule

// File: rtl/altspace_mover.sv
`timescale 1ns/1ps
module altspace_mover
  import altspace_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int CW = FC_W,
  parameter int RW = RIDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   opcode,
  input  logic [15:0]   ext,
  input  logic          supervisor,
  input  logic          cr_we,
  input  logic          cr_sel,
  input  logic [DW-1:0] cr_wdata,
  output logic [CW-1:0] cr_rdata,
  output logic [RW-1:0] rf_base_addr,
  input  logic [DW-1:0] rf_base_data,
  output logic [RW-1:0] rf_xfer_addr,
  input  logic [DW-1:0] rf_xfer_data,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] mem_fc,
  output logic          mem_super,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code
);
  state_e            state;
  fault_e            dec_fault, fcode_q;
  logic [1:0]        dec_size, size_q;
  logic [2:0]        dec_mode, dec_areg, areg_q;
  logic [RW-1:0]     dec_xidx, xidx_q;
  logic              dec_store, store_q, upd_q, fault_q;
  logic [CW-1:0]     src_fc, dst_fc, fc_q;
  logic [DW-1:0]     ag_addr, ag_new, addr_q, newa_q, load_q;
  logic              ag_upd;
  logic              idle_w, accept_w, reject_w, ack_w;
  logic              unused_bits;

  assign unused_bits = ^{cr_wdata[DW-1:CW], ext[10:0]};

  altspace_fcregs u_fc (
    .clk(clk), .rst_n(rst_n), .we(cr_we), .sel(cr_sel),
    .wdata(cr_wdata[CW-1:0]), .rdata(cr_rdata),
    .src_fc(src_fc), .dst_fc(dst_fc)
  );

  altspace_decode u_dec (
    .opcode(opcode), .ext_hi(ext[15:11]), .supervisor(supervisor),
    .fault_o(dec_fault), .size_o(dec_size), .mode_o(dec_mode),
    .areg_o(dec_areg), .xidx_o(dec_xidx), .store_o(dec_store)
  );

  altspace_agen u_ag (
    .base(rf_base_data), .size(dec_size), .mode(dec_mode), .areg(dec_areg),
    .acc_addr(ag_addr), .new_areg(ag_new), .upd(ag_upd)
  );

  // Named events used by the checker.
  assign idle_w   = (state == ST_IDLE);
  assign accept_w = start && idle_w && (dec_fault == FLT_NONE);
  assign reject_w = start && idle_w && (dec_fault != FLT_NONE);
  assign ack_w    = (state == ST_ACC) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fault_q <= 1'b0;
      fcode_q <= FLT_NONE;
      size_q  <= SZ_BYTE;
      areg_q  <= '0;
      xidx_q  <= '0;
      store_q <= 1'b0;
      upd_q   <= 1'b0;
      fc_q    <= '0;
      addr_q  <= '0;
      newa_q  <= '0;
      load_q  <= '0;
    end else begin
      fault_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reject_w) begin
            fault_q <= 1'b1;
            fcode_q <= dec_fault;
          end else if (accept_w) begin
            state   <= ST_ACC;
            size_q  <= dec_size;
            areg_q  <= dec_areg;
            xidx_q  <= dec_xidx;
            store_q <= dec_store;
            upd_q   <= ag_upd;
            fc_q    <= dec_store ? dst_fc : src_fc;
            addr_q  <= ag_addr;
            newa_q  <= ag_new;
          end
        end
        ST_ACC: begin
          if (ack_w) begin
            load_q <= mem_rdata;
            if (!store_q)   state <= ST_WBD;
            else if (upd_q) state <= ST_WBA;
            else            state <= ST_FIN;
          end
        end
        ST_WBD:  state <= upd_q ? ST_WBA : ST_FIN;
        ST_WBA:  state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rf_base_addr = {1'b1, idle_w ? opcode[2:0] : areg_q};
  assign rf_xfer_addr = xidx_q;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = xidx_q;
    rf_wdata = merge_load(size_q, xidx_q[RW-1], rf_xfer_data, load_q);
    if (state == ST_WBD) begin
      rf_we = 1'b1;
    end else if (state == ST_WBA) begin
      rf_we    = 1'b1;
      rf_waddr = {1'b1, areg_q};
      rf_wdata = newa_q;
    end
  end

  assign mem_req    = (state == ST_ACC);
  assign mem_we     = store_q;
  assign mem_size   = size_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = rf_xfer_data;
  assign mem_fc     = fc_q;
  assign mem_super  = fc_q[CW-1];
  assign busy       = !idle_w;
  assign done       = (state == ST_FIN);
  assign fault      = fault_q;
  assign fault_code = fcode_q;
endmodule

// File: rtl/altspace_mover_chk.sv
`timescale 1ns/1ps
module altspace_mover_chk #(
  parameter int DW = 32,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          supervisor,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic [1:0]    fault_code,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [CW-1:0] mem_fc,
  input logic          mem_super,
  input logic          cr_we,
  input logic          cr_sel,
  input logic [DW-1:0] cr_wdata,
  input logic [CW-1:0] cr_rdata,
  input logic          accept_w,
  input logic          reject_w
);
  p_user_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !supervisor) |=> (fault && fault_code == 2'd1 && !mem_req));

  p_reject_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> (fault && !mem_req && !busy));

  p_accept_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (mem_req && !fault));

  p_space_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_super == mem_fc[CW-1]));

  p_hold_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_fc) && $stable(mem_we)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, mem_req}));

  p_src_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && !cr_sel) |=> (cr_sel || cr_rdata == $past(cr_wdata[CW-1:0])));

  p_dst_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && cr_sel) |=> (!cr_sel || cr_rdata == $past(cr_wdata[CW-1:0])));
endmodule

bind altspace_mover altspace_mover_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .supervisor(supervisor),
  .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_fc(mem_fc), .mem_super(mem_super), .cr_we(cr_we), .cr_sel(cr_sel),
  .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
  .accept_w(accept_w), .reject_w(reject_w)
);

// File: tb/altspace_mover_test.sv
`timescale 1ns/1ps
module altspace_mover_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, supervisor = 1'b0;
  logic [15:0] opcode = '0, ext = '0;
  logic        cr_we = 1'b0, cr_sel = 1'b0;
  logic [31:0] cr_wdata = '0;
  logic [2:0]  cr_rdata;
  logic [3:0]  rf_base_addr, rf_xfer_addr, rf_waddr;
  logic [31:0] rf_base_data, rf_xfer_data, rf_wdata;
  logic        rf_we, mem_req, mem_we, mem_super, busy, done, fault;
  logic [1:0]  mem_size, fault_code;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0]  mem_fc;
  logic        mem_ack = 1'b0;

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  altspace_mover uut (.*);

  // Behavioural register file with a preload path.
  logic [31:0] rf [16];
  logic        pl_en = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_val = '0;
  assign rf_base_data = rf[rf_base_addr];
  assign rf_xfer_data = rf[rf_xfer_addr];
  always @(posedge clk) begin
    if (pl_en)      rf[pl_idx]   <= pl_val;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  function automatic logic [31:0] mem_pattern(input logic [31:0] a);
    return {8'h5A, a[7:0], ~a[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus model with expectations set by the driver.
  logic        exp_on = 1'b0, exp_we = 1'b0;
  logic [31:0] exp_addr = '0, exp_wdata = '0;
  logic [2:0]  exp_fc = '0;
  logic [1:0]  exp_size = '0;
  int          wait_cfg = 0, wcnt = 0;

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wcnt >= wait_cfg) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_pattern(mem_addr);
        wcnt      <= 0;
        if (exp_on) begin
          check("R9/R10 address", mem_addr, exp_addr);
          check("R4 direction", {31'd0, mem_we}, {31'd0, exp_we});
          check("R4/R12 function code", {29'd0, mem_fc}, {29'd0, exp_fc});
          check("R8 space select", {31'd0, mem_super}, {31'd0, exp_fc[2]});
          check("R1 size", {30'd0, mem_size}, {30'd0, exp_size});
          if (exp_we) check("R4 store data", mem_wdata, exp_wdata);
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic preload(input int idx, input logic [31:0] v);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = 4'(idx); pl_val = v;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic cr_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    cr_we = 1'b1; cr_sel = sel; cr_wdata = v;
    @(negedge clk);
    cr_we = 1'b0;
  endtask

  function automatic logic [15:0] mk_op(input int sz, input int mode, input int r);
    return 16'h0E00 | 16'(sz << 6) | 16'(mode << 3) | 16'(r);
  endfunction

  function automatic logic [15:0] mk_ext(input int cls, input int num, input int st);
    return 16'(cls << 15) | 16'(num << 12) | 16'(st << 11);
  endfunction

  // Issue one instruction and compare against the model.
  task automatic run(input logic [15:0] op, input logic [15:0] ex, input logic sup,
                     input int wt, input logic [2:0] sfc_m, input logic [2:0] dfc_m);
    logic [1:0]  sz = op[7:6];
    int          mode = int'(op[5:3]);
    int          ar = int'(op[2:0]);
    int          xi = int'({ex[15], ex[14:12]});
    logic        st = ex[11];
    int          efault;
    logic [31:0] step, base, acc, newa, ld, old_x, exp_x;
    bit          upd;
    int          cyc, ack_cyc, done_cyc;

    if (!sup) efault = 1;
    else if (op[15:8] != 8'h0E || sz == 2'b11) efault = 2;
    else if (mode < 2 || mode > 4) efault = 3;
    else efault = 0;

    step  = (sz == 2'b00) ? ((ar == 7) ? 32'd2 : 32'd1) : (sz == 2'b01) ? 32'd2 : 32'd4;
    base  = rf[8 + ar];
    old_x = rf[xi];
    acc   = (mode == 4) ? base - step : base;
    newa  = (mode == 3) ? base + step : base - step;
    upd   = (mode == 3 || mode == 4);
    ld    = mem_pattern(acc);
    if (sz == 2'b00)      exp_x = ex[15] ? {{24{ld[7]}}, ld[7:0]}   : {old_x[31:8], ld[7:0]};
    else if (sz == 2'b01) exp_x = ex[15] ? {{16{ld[15]}}, ld[15:0]} : {old_x[31:16], ld[15:0]};
    else                  exp_x = ld;

    exp_addr = acc; exp_we = st; exp_fc = st ? dfc_m : sfc_m;
    exp_size = sz; exp_wdata = old_x; wait_cfg = wt;
    exp_on = (efault == 0);

    @(negedge clk);
    start = 1'b1; opcode = op; ext = ex; supervisor = sup;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (efault != 0) begin
      check("R1/R2/R11 fault pulse", {31'd0, fault}, 32'd1);
      check("R1/R2/R11 fault code", {30'd0, fault_code}, 32'(efault));
      check("R2/R11 no bus", {31'd0, mem_req}, 32'd0);
      exp_on = 1'b0;
      return;
    end
    ack_cyc = -1; done_cyc = -1;
    for (cyc = 0; cyc < 40; cyc++) begin
      if (mem_ack && ack_cyc < 0) ack_cyc = cyc;
      if (done) begin done_cyc = cyc; break; end
      @(negedge clk); #1;
    end
    check("R12 done latency", 32'(done_cyc - ack_cyc), 32'(1 + (st ? 0 : 1) + (upd ? 1 : 0)));
    @(negedge clk); #1;
    check("R12 done one cycle", {31'd0, done}, 32'd0);
    exp_on = 1'b0;
    if (!st) check(ex[15] ? "R5 address load" : "R6 data load", rf[xi], exp_x);
    if (upd) check((mode == 3) ? "R9 postincrement" : "R10 predecrement", rf[8 + ar], newa);
    else     check("R10 mode 2 keeps An", rf[8 + ar], base);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1111_0000 * i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R12 reset busy", {31'd0, busy}, 32'd0);
    check("R12 reset done/fault/req", {29'd0, done, fault, mem_req}, 32'd0);
    check("R7 reset code", {29'd0, cr_rdata}, 32'd0);

    cr_write(1'b0, 32'h0000_000F);
    check("R7 source mask", {29'd0, cr_rdata}, 32'd7);
    cr_write(1'b1, 32'hFFFF_FFF8);
    check("R7 destination mask", {29'd0, cr_rdata}, 32'd0);

    preload(9, 32'h0000_0100);   // A1
    preload(10, 32'h0000_0280);  // A2
    preload(15, 32'h0000_0400);  // A7
    preload(2, 32'hCAFE_BABE);   // D2
    preload(4, 32'hDEAD_BEEF);   // D4

    cr_write(1'b0, 32'd5); cr_write(1'b1, 32'd6);
    run(mk_op(0, 2, 1), mk_ext(0, 2, 0), 1'b1, 0, 3'd5, 3'd6);  // R3 R6 byte load, mode 2
    cr_write(1'b0, 32'd1);
    run(mk_op(1, 3, 1), mk_ext(1, 3, 0), 1'b1, 2, 3'd1, 3'd6);  // R5 word into A3, R9
    run(mk_op(0, 3, 2), mk_ext(1, 4, 0), 1'b1, 1, 3'd1, 3'd6);  // R5 positive byte, R9
    run(mk_op(0, 3, 7), mk_ext(0, 5, 0), 1'b1, 0, 3'd1, 3'd6);  // R9 A7 byte step 2
    run(mk_op(2, 4, 2), mk_ext(0, 4, 1), 1'b1, 1, 3'd1, 3'd6);  // R4 R10 long store
    run(mk_op(0, 4, 7), mk_ext(0, 4, 1), 1'b1, 0, 3'd1, 3'd6);  // R10 A7 byte step 2
    run(mk_op(2, 3, 1), mk_ext(0, 0, 0), 1'b1, 0, 3'd1, 3'd6);  // R6 long load, R9 step 4
    run(mk_op(1, 2, 2), mk_ext(0, 6, 0), 1'b1, 0, 3'd1, 3'd6);  // R6 word merge

    run(mk_op(0, 2, 1), mk_ext(0, 2, 0), 1'b0, 0, 3'd1, 3'd6);  // R2 privilege
    run(mk_op(3, 2, 1), mk_ext(0, 2, 0), 1'b0, 0, 3'd1, 3'd6);  // R2 wins over R1
    run(mk_op(3, 2, 1), mk_ext(0, 2, 0), 1'b1, 0, 3'd1, 3'd6);  // R1 size 11
    run(16'h0F11, mk_ext(0, 2, 0), 1'b1, 0, 3'd1, 3'd6);        // R1 wrong opcode
    run(mk_op(0, 0, 1), mk_ext(0, 2, 0), 1'b1, 0, 3'd1, 3'd6);  // R11 register direct
    run(mk_op(1, 7, 4), mk_ext(0, 2, 0), 1'b1, 0, 3'd1, 3'd6);  // R11 mode 7

    // R12: a destination-code write during a held access does not reach the bus.
    fork
      run(mk_op(2, 2, 1), mk_ext(0, 3, 1), 1'b1, 4, 3'd1, 3'd6);
      begin
        repeat (2) @(negedge clk);
        cr_write(1'b1, 32'd2);
      end
    join
    run(mk_op(2, 2, 1), mk_ext(0, 3, 1), 1'b1, 0, 3'd1, 3'd2);  // R12 new code next time

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule